// File: doc/BRIEF.md
# Fixed-Format Serial Receiver on a 32 kHz Clock

This block receives asynchronous serial characters using nothing but a 32.768 kHz reference clock, so it stays alive while the bus and configuration clocks are gated off. The format is fixed: 9600 baud, one low start bit, eight data bits sent least significant first, and one stop bit. At that rate a bit lasts only about 3.41 reference clocks. A fractional phase accumulator therefore replaces the usual oversampling counter. It adds the baud rate every clock and marks a sample point each time the sum wraps past the clock rate.

Software arms the receiver with a one-cycle enable strobe and disarms it with a separate one-cycle disable strobe. Each good character updates the data register and produces a one-cycle event pulse and a one-cycle wake-up pulse. A low stop bit sets a sticky framing-error flag instead. The next enable strobe clears that flag.

Top module: `lowclk_uart_rx`

## Requirements
- R1: After reset, rx_data is 0, data_event, wake_pulse and frame_err are low, and the receiver is disarmed, so a frame sent before any enable strobe produces no pulse.
- R2: An enable strobe arms the receiver. A disable strobe disarms it, and when both strobes come in the same cycle the disable wins. Frames that arrive while disarmed produce no pulse and leave rx_data unchanged.
- R3: A frame is a low start bit, eight data bits with bit 0 first, and a high stop bit. Each bit lasts CLK_HZ/BAUD reference clocks (32768/9600 by default). The eight data bits land in rx_data, with the first received bit in rx_data[0].
- R4: A frame with a high stop bit causes exactly one data_event pulse and one wake_pulse, each one cycle long. Both pulses fall in the same cycle as the rx_data update, and rx_data changes at no other time.
- R5: A low level on the line that is already high again at the first mid-bit sample is a glitch. It produces no pulse and no error, and a normal frame received afterwards is decoded correctly.
- R6: A low stop bit sets frame_err and produces no pulse, and rx_data keeps its previous value. frame_err stays set through later good frames.
- R7: frame_err is cleared by the next enable strobe and by nothing else.
- R8: A disable strobe during a frame drops that frame at once. No pulse follows for it, and after the receiver is armed again the next frame is received normally.
- R9: Two frames sent back to back, with the second start bit directly after the first stop bit, are both received in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 32.768 kHz reference clock; the only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input, idle high |
| rx_on_stb | input | 1 | One-cycle strobe that arms reception and clears frame_err |
| rx_off_stb | input | 1 | One-cycle strobe that disarms reception and drops any frame in progress |
| rx_data | output | DATA_W | Last correctly received character |
| data_event | output | 1 | One-cycle pulse per good character |
| wake_pulse | output | 1 | One-cycle wake-up pulse per good character |
| frame_err | output | 1 | Sticky flag for a low stop bit |

## Verification
The hardest case to reach is a disable strobe that lands in the middle of a frame. After it, the tail of the dropped frame still toggles the line while the receiver is disarmed, and the bench must show that neither those edges nor the dropped bits leak into a pulse or into rx_data. The bench runs the frame transmitter and the strobe driver as parallel threads. It fires the disable strobe a fixed number of cycles into the data bits, re-arms the receiver only after the line has gone idle, and then expects the following frame to decode cleanly. The transmitter places each bit boundary at the integer floor of k·32768/9600. The receiver's fractional sampling is therefore tested against 3-clock and 4-clock bits mixed inside every frame.

// File: rtl/lowclk_uart_rx.sv
module lowclk_uart_rx #(
  parameter int CLK_HZ = 32768,
  parameter int BAUD   = 9600,
  parameter int DATA_W = 8
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              rx_on_stb,
  input  logic              rx_off_stb,
  output logic [DATA_W-1:0] rx_data,
  output logic              data_event,
  output logic              wake_pulse,
  output logic              frame_err
);

  localparam int ACC_W = $clog2(CLK_HZ + BAUD + 1);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [ACC_W-1:0] FULL    = ACC_W'(CLK_HZ);
  localparam logic [ACC_W-1:0] INC     = ACC_W'(BAUD);
  // first wrap one clock after start detection, absorbing synchronizer lag
  localparam logic [ACC_W-1:0] PRELOAD = ACC_W'(CLK_HZ - BAUD / 2);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(DATA_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_t;

  logic              sync1, sync2, line_q;
  logic              armed;
  rx_state_t         state;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  sum;
  logic              tick;
  logic              fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              stop_bad;

  assign sum      = acc + INC;
  assign tick     = (sum >= FULL);
  assign fall     = line_q & ~sync2;
  assign stop_bad = (state == ST_STOP) && tick && !sync2 && !rx_off_stb;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= 1'b1;
      sync2  <= 1'b1;
      line_q <= 1'b1;
    end else begin
      sync1  <= rx_line;
      sync2  <= sync1;
      line_q <= sync2;
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      state      <= ST_IDLE;
      acc        <= '0;
      bit_cnt    <= '0;
      shreg      <= '0;
      rx_data    <= '0;
      data_event <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      data_event <= 1'b0;
      wake_pulse <= 1'b0;
      if (rx_off_stb) begin
        armed <= 1'b0;
        state <= ST_IDLE;
      end else begin
        if (rx_on_stb) armed <= 1'b1;
        if (state != ST_IDLE) acc <= tick ? sum - FULL : sum;
        case (state)
          ST_IDLE: begin
            if (armed && fall) begin
              state <= ST_START;
              acc   <= PRELOAD;
            end
          end
          ST_START: begin
            if (tick) begin
              bit_cnt <= '0;
              state   <= sync2 ? ST_IDLE : ST_DATA;
            end
          end
          ST_DATA: begin
            if (tick) begin
              shreg   <= {sync2, shreg[DATA_W-1:1]};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST) state <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (tick) begin
              state <= ST_IDLE;
              if (sync2) begin
                rx_data    <= shreg;
                data_event <= 1'b1;
                wake_pulse <= 1'b1;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)         frame_err <= 1'b0;
    else if (stop_bad)  frame_err <= 1'b1;
    else if (rx_on_stb) frame_err <= 1'b0;
  end

  // R4
  event_one_cycle_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    data_event |=> !data_event);

  // R4
  data_only_on_event_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (rx_data != $past(rx_data)) |-> data_event);

  // R8
  off_drops_frame_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    rx_off_stb |=> (!data_event && state == ST_IDLE));

  // R6
  err_sticky_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (frame_err && !rx_on_stb) |=> frame_err);

  // R6
  no_event_on_err_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(frame_err) |-> !data_event);

  // R7
  err_clear_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (rx_on_stb && state != ST_STOP) |=> !frame_err);

  // R2
  disarmed_quiet_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!armed && state == ST_IDLE) |=> state == ST_IDLE);

endmodule

// File: tb/test_lowclk_uart_rx.sv
module test_lowclk_uart_rx;
  localparam int CLK_HZ = 32768;
  localparam int BAUD   = 9600;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       on_stb = 1'b0;
  logic       off_stb = 1'b0;
  logic [7:0] rx_data;
  logic       data_event, wake_pulse, frame_err;

  int errors = 0;
  int checks = 0;
  int ev_cnt = 0;
  int wk_cnt = 0;
  int pair_bad = 0;
  int long_bad = 0;
  logic [7:0] cap [0:3];
  logic prev_ev = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  lowclk_uart_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(8)) i_lowclk_uart_rx (
    .clk_ref(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_on_stb(on_stb),
    .rx_off_stb(off_stb), .rx_data(rx_data), .data_event(data_event),
    .wake_pulse(wake_pulse), .frame_err(frame_err));

  always @(negedge clk) begin
    if (data_event) begin
      if (ev_cnt < 4) cap[ev_cnt] = rx_data;
      ev_cnt++;
    end
    if (wake_pulse) wk_cnt++;
    if (data_event != wake_pulse) pair_bad++;
    if (data_event && prev_ev) long_bad++;
    prev_ev = data_event;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe_on();
    @(negedge clk) on_stb = 1'b1;
    @(negedge clk) on_stb = 1'b0;
  endtask

  task automatic strobe_off();
    @(negedge clk) off_stb = 1'b1;
    @(negedge clk) off_stb = 1'b0;
  endtask

  task automatic send_frame(logic [7:0] b, logic stop);
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      rx_line = (k == 0) ? 1'b0 : (k == 9) ? stop : b[k-1];
      repeat (((k + 1) * CLK_HZ) / BAUD - (k * CLK_HZ) / BAUD) @(negedge clk);
    end
    rx_line = 1'b1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    idle(3);
    chk("R1 rx_data", rx_data, 0);
    chk("R1 data_event", data_event, 0);
    chk("R1 wake_pulse", wake_pulse, 0);
    chk("R1 frame_err", frame_err, 0);
    send_frame(8'h5A, 1'b1);
    idle(10);
    chk("R1 no event before enable", ev_cnt, 0);
  endtask

  task automatic t_basic();
    logic [7:0] pats [0:3];
    pats[0] = 8'hA5; pats[1] = 8'h00; pats[2] = 8'hFF; pats[3] = 8'h01;
    strobe_on();
    idle(4);
    for (int i = 0; i < 4; i++) begin
      int e0 = ev_cnt;
      int w0 = wk_cnt;
      send_frame(pats[i], 1'b1);
      idle(10);
      chk("R3 one event per frame", ev_cnt - e0, 1);
      chk("R4 one wake per frame", wk_cnt - w0, 1);
      chk("R3 rx_data value", rx_data, pats[i]);
      if (ev_cnt <= 4) chk("R4 data valid at pulse", cap[ev_cnt-1], pats[i]);
    end
    chk("R4 pulses coincide", pair_bad, 0);
    chk("R4 single-cycle pulse", long_bad, 0);
  endtask

  task automatic t_disable();
    int e0;
    strobe_off();
    e0 = ev_cnt;
    send_frame(8'h3C, 1'b1);
    idle(10);
    chk("R2 disarmed ignores frame", ev_cnt - e0, 0);
    chk("R2 rx_data held", rx_data, 8'h01);
    @(negedge clk) begin on_stb = 1'b1; off_stb = 1'b1; end
    @(negedge clk) begin on_stb = 1'b0; off_stb = 1'b0; end
    send_frame(8'h3C, 1'b1);
    idle(10);
    chk("R2 disable wins over enable", ev_cnt - e0, 0);
    strobe_on();
    send_frame(8'h3C, 1'b1);
    idle(10);
    chk("R2 re-armed receives", ev_cnt - e0, 1);
    chk("R2 re-armed data", rx_data, 8'h3C);
  endtask

  task automatic t_glitch();
    int e0 = ev_cnt;
    @(negedge clk) rx_line = 1'b0;
    @(negedge clk) rx_line = 1'b1;
    idle(10);
    chk("R5 glitch gives no event", ev_cnt - e0, 0);
    chk("R5 glitch gives no error", frame_err, 0);
    send_frame(8'h96, 1'b1);
    idle(10);
    chk("R5 frame after glitch", rx_data, 8'h96);
  endtask

  task automatic t_frame_err();
    int e0 = ev_cnt;
    send_frame(8'h55, 1'b0);
    idle(10);
    chk("R6 frame_err set", frame_err, 1);
    chk("R6 no event on bad stop", ev_cnt - e0, 0);
    chk("R6 rx_data kept", rx_data, 8'h96);
    send_frame(8'h7E, 1'b1);
    idle(10);
    chk("R6 error sticky over good frame", frame_err, 1);
    chk("R6 good frame still received", rx_data, 8'h7E);
    strobe_on();
    idle(2);
    chk("R7 enable clears frame_err", frame_err, 0);
  endtask

  task automatic t_abort();
    int e0 = ev_cnt;
    fork
      send_frame(8'hC3, 1'b1);
      begin
        idle(15);
        strobe_off();
      end
    join
    idle(10);
    chk("R8 aborted frame no event", ev_cnt - e0, 0);
    chk("R8 aborted frame data kept", rx_data, 8'h7E);
    strobe_on();
    send_frame(8'h81, 1'b1);
    idle(10);
    chk("R8 next frame after re-arm", rx_data, 8'h81);
  endtask

  task automatic t_back_to_back();
    int e0 = ev_cnt;
    int base = ev_cnt;
    send_frame(8'h12, 1'b1);
    send_frame(8'hED, 1'b1);
    idle(10);
    chk("R9 two frames counted", ev_cnt - e0, 2);
    chk("R9 second byte last", rx_data, 8'hED);
    if (base < 4) chk("R9 first byte captured", cap[base], 8'h12);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_disable();
    t_glitch();
    t_frame_err();
    t_abort();
    t_back_to_back();
    chk("R4 pulses coincide overall", pair_bad, 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule